// File: doc/BRIEF.md
# Dual Stack Pointer Unit

This block generates addresses and data for two stacks that share one 256-entry, 4-bit-wide RAM. The operand stack is 4 bits wide. Its top element lives in a register, `tos`, and the RAM holds only the elements beneath it. Its pointer `sp` addresses the element directly under the top. The link stack stores 12-bit entries, each spread over three consecutive nibbles. Its pointer `rp` addresses the lowest nibble of the top entry and moves in steps of four, so the fourth nibble of every four-nibble group is never written by the block.

The RAM itself is outside the block. The block drives `ram_addr`, `ram_we` and `ram_wdata`, and it expects `ram_rdata` to return the contents of `ram_addr` in the same cycle. Both pointers reset to 00h. Software is expected to load them before use; the link pointer is usually loaded with FCh.

An operand push or pop takes one cycle. A link push or pop takes three cycles, one per nibble. The controller has three states:

- `ST_IDLE` accepts requests.
- `ST_RS_BEAT` runs beats 1 and 2 of a link access. Beat 0 happens in `ST_IDLE`.
- `ST_ES_LATE` performs an operand request that arrived together with a link request.

The controller moves between these states as follows:

- `ST_IDLE` goes to `ST_RS_BEAT` when a link request is accepted. It stays in `ST_IDLE` for an operand-only request, a load, or no request.
- `ST_RS_BEAT` stays in `ST_RS_BEAT` until the last beat.
- After the last beat, `ST_RS_BEAT` goes to `ST_ES_LATE` if an operand request is pending, and to `ST_IDLE` otherwise.
- `ST_ES_LATE` always returns to `ST_IDLE`.

`busy` is high in every state other than `ST_IDLE`.

Top module: `dual_stack_unit`

## Requirements
- R1: After reset, `tos`, `sp`, `rp` and `rs_dout` are zero, and `busy` and `ram_we` are low.
- R2: An accepted operand push drives `ram_addr` = `sp`+1, `ram_we`=1 and `ram_wdata` = old `tos` in the request cycle. After that clock edge, `sp` has gone up by 1 and `tos` equals `es_din`.
- R3: An accepted operand pop drives `ram_addr` = `sp` with `ram_we`=0 in the request cycle. After that edge, `tos` holds the nibble read and `sp` has gone down by 1.
- R4: A link push writes the data over three consecutive cycles:
  - bits 3:0 to address `rp`+4, in the request cycle;
  - bits 7:4 to `rp`+5;
  - bits 11:8 to `rp`+6.
  `rp` becomes `rp`+4 after the first edge, and `busy` is high in the second and third cycles.
- R5: A link pop reads addresses `rp`, `rp`+1 and `rp`+2 in three consecutive cycles. After the third edge, `rs_dout` = {nibble at `rp`+2, nibble at `rp`+1, nibble at `rp`} and `rp` has gone down by 4. Until that edge, `rs_dout` keeps its previous value.
- R6: The nibble at offset 3 above the lowest address of a link entry (`rp`+7 relative to the old pointer) is never written by a link push.
- R7: When operand and link requests arrive in the same cycle, the link access runs first. The operand access follows in the fourth cycle, using the `es_din` captured in the request cycle, and `busy` stays high through that fourth cycle.
- R8: `ld_sp` or `ld_rp`, accepted while idle, loads `ld_val` into the selected pointer. Every push and pop request in that cycle is ignored and no RAM write occurs.
- R9: All requests, loads included, are ignored while `busy` is high.
- R10: Pointer arithmetic wraps modulo 256. Examples: `sp` FFh pushes to 00h, `sp` 00h pops to FFh, and `rp` FCh pushes to 00h, writing addresses 00h–02h.
- R11: If push and pop of the same stack are requested together, the push is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| es_push | input | 1 | Operand stack push request |
| es_pop | input | 1 | Operand stack pop request |
| es_din | input | 4 | Value pushed onto the operand stack |
| rs_push | input | 1 | Link stack push request |
| rs_pop | input | 1 | Link stack pop request |
| rs_din | input | 12 | Entry pushed onto the link stack |
| ld_sp | input | 1 | Load operand pointer |
| ld_rp | input | 1 | Load link pointer |
| ld_val | input | 8 | Value for pointer loads |
| ram_rdata | input | 4 | Read data for the current `ram_addr` |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 4 | RAM write data |
| tos | output | 4 | Top-of-stack register |
| sp | output | 8 | Operand pointer (element under top) |
| rp | output | 8 | Link pointer (lowest nibble of top entry) |
| rs_dout | output | 12 | Last entry popped from the link stack |
| busy | output | 1 | Multi-cycle access in progress |

## Verification
Results do not all appear at the same cycle:

- Operand results, pointer loads and the `rp` step of a link push appear after the first clock edge following the request.
- Link pop data and the `rp` decrement appear after the third edge.
- A deferred operand access lands after the fourth edge.

The bench drives inputs and samples outputs at falling edges. It checks RAM address, write strobe and write data one time unit after driving, within the cycle that performs the access. It compares pointer and data results only once `busy` has dropped, against a bench model that applies link before operand. The nibble-by-nibble timing of link pops, the held `rs_dout` and the fourth-cycle operand access are checked cycle by cycle at the falling edge of the named cycle.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
    localparam int PTR_W      = 8;
    localparam int NIB_W      = 4;
    localparam int ENTRY_NIBS = 3;
    localparam int RP_STEP    = 4;
    localparam int ENTRY_W    = NIB_W * ENTRY_NIBS;
    localparam int IDX_W      = $clog2(ENTRY_NIBS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RS_BEAT,
        ST_ES_LATE
    } dsu_state_e;
endpackage

// File: rtl/dsu_ctrl.sv
module dsu_ctrl
    import dsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             es_push,
    input  logic             es_pop,
    input  logic [NIB_W-1:0] es_din,
    input  logic             rs_push,
    input  logic             rs_pop,
    input  logic             ld_any,
    output logic             busy,
    output logic             es_step,
    output logic             es_dir_push,
    output logic [NIB_W-1:0] es_val,
    output logic             rs_step,
    output logic             rs_dir_push,
    output logic [IDX_W-1:0] rs_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRY_NIBS - 1);

    dsu_state_e       state_q, state_d;
    logic [IDX_W-1:0] beat_q;
    logic             rs_dir_q, es_pend_q, es_dir_q;
    logic [NIB_W-1:0] es_din_q;
    logic             rs_req, es_req, take_rs;

    assign rs_req  = rs_push | rs_pop;
    assign es_req  = es_push | es_pop;
    assign take_rs = (state_q == ST_IDLE) && !ld_any && rs_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured request context for multi-cycle accesses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q    <= '0;
            rs_dir_q  <= 1'b0;
            es_pend_q <= 1'b0;
            es_dir_q  <= 1'b0;
            es_din_q  <= '0;
        end else if (take_rs) begin
            beat_q    <= IDX_W'(1);
            rs_dir_q  <= rs_push;
            es_pend_q <= es_req;
            es_dir_q  <= es_push;
            es_din_q  <= es_din;
        end else if (state_q == ST_RS_BEAT && beat_q != LAST) begin
            beat_q <= beat_q + IDX_W'(1);
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        busy        = (state_q != ST_IDLE);
        es_step     = 1'b0;
        es_dir_push = 1'b0;
        es_val      = es_din_q;
        rs_step     = 1'b0;
        rs_dir_push = rs_dir_q;
        rs_idx      = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                rs_idx = '0;
                es_val = es_din;
                if (!ld_any) begin
                    if (rs_req) begin
                        rs_step     = 1'b1;
                        rs_dir_push = rs_push;
                        state_d     = ST_RS_BEAT;
                    end else if (es_req) begin
                        es_step     = 1'b1;
                        es_dir_push = es_push;
                    end
                end
            end
            ST_RS_BEAT: begin
                rs_step = 1'b1;
                if (beat_q == LAST)
                    state_d = es_pend_q ? ST_ES_LATE : ST_IDLE;
            end
            ST_ES_LATE: begin
                es_step     = 1'b1;
                es_dir_push = es_dir_q;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R4: link beats follow one another with rising index
    a_r4_beats_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_step && rs_idx != LAST) |=> (rs_step && rs_idx == $past(rs_idx) + IDX_W'(1)));

    // R7: a pending operand request runs right after the last link beat
    a_r7_es_follows_rs: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_step && rs_idx == LAST && es_pend_q) |=> (es_step && busy));

    // R9: the two datapaths never claim the RAM port in the same cycle
    a_r9_single_user: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({es_step, rs_step}));
endmodule

// File: rtl/dsu_es.sv
module dsu_es
    import dsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    input  logic             step,
    input  logic             dir_push,
    input  logic [NIB_W-1:0] din,
    input  logic [NIB_W-1:0] rdata,
    output logic [PTR_W-1:0] sp,
    output logic [NIB_W-1:0] tos,
    output logic [PTR_W-1:0] addr,
    output logic             we,
    output logic [NIB_W-1:0] wdata
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    assign addr  = dir_push ? sp + ONE : sp;
    assign we    = step & dir_push;
    assign wdata = tos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp  <= '0;
            tos <= '0;
        end else if (ld) begin
            sp <= ld_val;
        end else if (step) begin
            if (dir_push) begin
                sp  <= sp + ONE;
                tos <= din;
            end else begin
                tos <= rdata;
                sp  <= sp - ONE;
            end
        end
    end

    // R2: push raises the pointer and loads the new top
    a_r2_push_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dir_push) |=> (sp == $past(sp) + ONE && tos == $past(din)));

    // R3: pop lowers the pointer and the read nibble becomes the top
    a_r3_pop_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !dir_push) |=> (sp == $past(sp) - ONE && tos == $past(rdata)));
endmodule

// File: rtl/dsu_rs.sv
module dsu_rs
    import dsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld,
    input  logic [PTR_W-1:0]   ld_val,
    input  logic               step,
    input  logic               dir_push,
    input  logic [IDX_W-1:0]   idx,
    input  logic [ENTRY_W-1:0] din,
    input  logic [NIB_W-1:0]   rdata,
    output logic [PTR_W-1:0]   rp,
    output logic [ENTRY_W-1:0] dout,
    output logic [PTR_W-1:0]   addr,
    output logic               we,
    output logic [NIB_W-1:0]   wdata
);
    localparam logic [PTR_W-1:0] STEP_V = PTR_W'(RP_STEP);
    localparam logic [IDX_W-1:0] LAST   = IDX_W'(ENTRY_NIBS - 1);

    logic [ENTRY_W-1:0]       din_q;
    logic [ENTRY_W-NIB_W-1:0] gather_q;
    logic [ENTRY_W-1:0]       src;

    assign addr  = (dir_push && idx == '0) ? rp + STEP_V : rp + PTR_W'(idx);
    assign we    = step & dir_push;
    assign src   = (idx == '0) ? din : din_q;
    assign wdata = src[idx*NIB_W +: NIB_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp       <= '0;
            din_q    <= '0;
            gather_q <= '0;
            dout     <= '0;
        end else if (ld) begin
            rp <= ld_val;
        end else if (step) begin
            if (dir_push) begin
                if (idx == '0) begin
                    rp    <= rp + STEP_V;
                    din_q <= din;
                end
            end else if (idx == LAST) begin
                dout <= {rdata, gather_q};
                rp   <= rp - STEP_V;
            end else begin
                gather_q[idx*NIB_W +: NIB_W] <= rdata;
            end
        end
    end

    // R4: first push beat advances the pointer by one group
    a_r4_rp_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dir_push && idx == '0) |=> rp == $past(rp) + STEP_V);

    // R5: last pop beat retires the group and presents the high nibble
    a_r5_rp_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !dir_push && idx == LAST) |=>
            (rp == $past(rp) - STEP_V && dout[ENTRY_W-1 -: NIB_W] == $past(rdata)));
endmodule

// File: rtl/dual_stack_unit.sv
module dual_stack_unit
    import dsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               es_push,
    input  logic               es_pop,
    input  logic [NIB_W-1:0]   es_din,
    input  logic               rs_push,
    input  logic               rs_pop,
    input  logic [ENTRY_W-1:0] rs_din,
    input  logic               ld_sp,
    input  logic               ld_rp,
    input  logic [PTR_W-1:0]   ld_val,
    input  logic [NIB_W-1:0]   ram_rdata,
    output logic [PTR_W-1:0]   ram_addr,
    output logic               ram_we,
    output logic [NIB_W-1:0]   ram_wdata,
    output logic [NIB_W-1:0]   tos,
    output logic [PTR_W-1:0]   sp,
    output logic [PTR_W-1:0]   rp,
    output logic [ENTRY_W-1:0] rs_dout,
    output logic               busy
);
    logic             es_step, es_dir_push, rs_step, rs_dir_push;
    logic [NIB_W-1:0] es_val;
    logic [IDX_W-1:0] rs_idx;
    logic [PTR_W-1:0] es_addr, rs_addr;
    logic             es_we, rs_we;
    logic [NIB_W-1:0] es_wdata, rs_wdata;
    logic             ld_sp_ok, ld_rp_ok;

    assign ld_sp_ok = ld_sp & ~busy;
    assign ld_rp_ok = ld_rp & ~busy;

    dsu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .es_push(es_push), .es_pop(es_pop), .es_din(es_din),
        .rs_push(rs_push), .rs_pop(rs_pop), .ld_any(ld_sp | ld_rp),
        .busy(busy), .es_step(es_step), .es_dir_push(es_dir_push), .es_val(es_val),
        .rs_step(rs_step), .rs_dir_push(rs_dir_push), .rs_idx(rs_idx)
    );

    dsu_es u_es (
        .clk(clk), .rst_n(rst_n), .ld(ld_sp_ok), .ld_val(ld_val),
        .step(es_step), .dir_push(es_dir_push), .din(es_val), .rdata(ram_rdata),
        .sp(sp), .tos(tos), .addr(es_addr), .we(es_we), .wdata(es_wdata)
    );

    dsu_rs u_rs (
        .clk(clk), .rst_n(rst_n), .ld(ld_rp_ok), .ld_val(ld_val),
        .step(rs_step), .dir_push(rs_dir_push), .idx(rs_idx), .din(rs_din),
        .rdata(ram_rdata), .rp(rp), .dout(rs_dout),
        .addr(rs_addr), .we(rs_we), .wdata(rs_wdata)
    );

    always_comb begin
        if (rs_step) begin
            ram_addr  = rs_addr;
            ram_we    = rs_we;
            ram_wdata = rs_wdata;
        end else begin
            ram_addr  = es_addr;
            ram_we    = es_we;
            ram_wdata = es_wdata;
        end
    end

    // R8: an accepted pointer load never writes the RAM
    a_r8_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_sp || ld_rp) && !busy) |-> !ram_we);
endmodule

// File: tb/dual_stack_unit_test.sv
`timescale 1ns/1ps
module dual_stack_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        es_push = 0, es_pop = 0, rs_push = 0, rs_pop = 0, ld_sp = 0, ld_rp = 0;
    logic [3:0]  es_din = '0;
    logic [11:0] rs_din = '0;
    logic [7:0]  ld_val = '0;
    logic [3:0]  ram_rdata, ram_wdata, tos;
    logic [7:0]  ram_addr, sp, rp;
    logic        ram_we, busy;
    logic [11:0] rs_dout;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_stack_unit uut (.*);

    function automatic logic [3:0] init_nib(int i);
        return 4'(i * 7 + 3);
    endfunction

    logic [3:0] mem [256];
    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_nib(i);
        end else if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
        end
    end

    logic [7:0]  m_sp = 0, m_rp = 0;
    logic [3:0]  m_tos = 0;
    logic [11:0] m_rsout = 0;
    logic [3:0]  m_mem [256];

    logic a_ep, a_eq, a_rp, a_rq, a_lsp, a_lrp;
    logic [3:0]  a_ed;
    logic [11:0] a_rd;
    logic [7:0]  a_lv;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_apply();
        if (a_lsp || a_lrp) begin
            if (a_lsp) m_sp = a_lv;
            if (a_lrp) m_rp = a_lv;
        end else begin
            if (a_rp) begin
                m_rp = m_rp + 8'd4;
                m_mem[m_rp]        = a_rd[3:0];
                m_mem[8'(m_rp+1)]  = a_rd[7:4];
                m_mem[8'(m_rp+2)]  = a_rd[11:8];
            end else if (a_rq) begin
                m_rsout = {m_mem[8'(m_rp+2)], m_mem[8'(m_rp+1)], m_mem[m_rp]};
                m_rp = m_rp - 8'd4;
            end
            if (a_ep) begin
                m_sp = m_sp + 8'd1;
                m_mem[m_sp] = m_tos;
                m_tos = a_ed;
            end else if (a_eq) begin
                m_tos = m_mem[m_sp];
                m_sp = m_sp - 8'd1;
            end
        end
    endtask

    task automatic start_op(input logic ep, eq, input logic [3:0] ed,
                            input logic rp_, rq, input logic [11:0] rd,
                            input logic lsp, lrp, input logic [7:0] lv);
        @(negedge clk);
        a_ep = ep; a_eq = eq; a_ed = ed; a_rp = rp_; a_rq = rq; a_rd = rd;
        a_lsp = lsp; a_lrp = lrp; a_lv = lv;
        es_push = ep; es_pop = eq; es_din = ed; rs_push = rp_; rs_pop = rq; rs_din = rd;
        ld_sp = lsp; ld_rp = lrp; ld_val = lv;
        #1;
    endtask

    task automatic clear_in();
        es_push = 0; es_pop = 0; rs_push = 0; rs_pop = 0; ld_sp = 0; ld_rp = 0;
    endtask

    task automatic finish_op();
        @(posedge clk);
        @(negedge clk);
        clear_in();
        while (busy) @(negedge clk);
        model_apply();
    endtask

    task automatic cmp_state(input string tag);
        chk({tag, " sp"}, 32'(sp), 32'(m_sp));
        chk({tag, " rp"}, 32'(rp), 32'(m_rp));
        chk({tag, " tos"}, 32'(tos), 32'(m_tos));
        chk({tag, " rs_dout"}, 32'(rs_dout), 32'(m_rsout));
    endtask

    task automatic cmp_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== m_mem[i]) bad++;
        chk(tag, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) m_mem[i] = init_nib(i);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 tos", 32'(tos), 0);
        chk("R1 sp", 32'(sp), 0);
        chk("R1 rp", 32'(rp), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rs_dout", 32'(rs_dout), 0);
        chk("R1 ram_we", 32'(ram_we), 0);

        // R8: load sp with a push in the same cycle, which must be ignored
        start_op(1, 0, 4'hD, 0, 0, 12'h0, 1, 0, 8'h10);
        chk("R8 no write on load", 32'(ram_we), 0);
        finish_op();
        cmp_state("R8 load sp");
        start_op(0, 0, 4'h0, 1, 0, 12'h777, 0, 1, 8'hFC);
        chk("R8 no write on load rp", 32'(ram_we), 0);
        finish_op();
        cmp_state("R8 load rp");

        // R2: operand push
        start_op(1, 0, 4'hA, 0, 0, 12'h0, 0, 0, 8'h0);
        chk("R2 addr", 32'(ram_addr), 32'h11);
        chk("R2 we", 32'(ram_we), 1);
        chk("R2 wdata", 32'(ram_wdata), 0);
        finish_op();
        cmp_state("R2 push");

        // R4 R10 R6: link push wrapping from FCh
        start_op(0, 0, 4'h0, 1, 0, 12'hABC, 0, 0, 8'h0);
        chk("R4 beat0 addr", 32'(ram_addr), 32'h00);
        chk("R4 beat0 wdata", 32'(ram_wdata), 32'hC);
        @(posedge clk); @(negedge clk); clear_in(); #1;
        chk("R4 busy beat1", 32'(busy), 1);
        chk("R10 rp wrap", 32'(rp), 32'h00);
        chk("R4 beat1 addr", 32'(ram_addr), 32'h01);
        chk("R4 beat1 wdata", 32'(ram_wdata), 32'hB);
        while (busy) @(negedge clk);
        model_apply();
        cmp_state("R4 push");
        chk("R4 mem2", 32'(mem[2]), 32'hA);
        chk("R6 gap nibble untouched", 32'(mem[3]), 32'(init_nib(3)));

        // R5: link pop, three reads, rs_dout only after the third edge
        start_op(0, 0, 4'h0, 0, 1, 12'h0, 0, 0, 8'h0);
        chk("R5 beat0 addr", 32'(ram_addr), 32'h00);
        chk("R5 beat0 we", 32'(ram_we), 0);
        @(posedge clk); @(negedge clk); clear_in();
        @(posedge clk); @(negedge clk); #1;
        chk("R5 busy beat2", 32'(busy), 1);
        chk("R5 beat2 addr", 32'(ram_addr), 32'h02);
        chk("R5 dout held", 32'(rs_dout), 32'(m_rsout));
        @(negedge clk);
        while (busy) @(negedge clk);
        model_apply();
        chk("R5 dout", 32'(rs_dout), 32'hABC);
        cmp_state("R5 pop");

        // R3: operand pop
        start_op(0, 1, 4'h0, 0, 0, 12'h0, 0, 0, 8'h0);
        chk("R3 addr", 32'(ram_addr), 32'(m_sp));
        chk("R3 we", 32'(ram_we), 0);
        finish_op();
        cmp_state("R3 pop");

        // R7: simultaneous requests, link first, operand in the fourth cycle
        start_op(1, 0, 4'h5, 1, 0, 12'h123, 0, 0, 8'h0);
        chk("R7 link first", 32'(ram_wdata), 32'h3);
        @(posedge clk); @(negedge clk); clear_in();
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk); #1;
        chk("R7 busy cycle4", 32'(busy), 1);
        chk("R7 es addr cycle4", 32'(ram_addr), 32'(m_sp + 8'd1));
        chk("R7 es wdata cycle4", 32'(ram_wdata), 32'(m_tos));
        while (busy) @(negedge clk);
        model_apply();
        cmp_state("R7 combined");

        // R9: operand push held during busy is ignored
        start_op(0, 0, 4'h0, 1, 0, 12'h456, 0, 0, 8'h0);
        @(posedge clk); @(negedge clk);
        clear_in(); es_push = 1; es_din = 4'h7; ld_sp = 1; ld_val = 8'h99;
        while (busy) @(negedge clk);
        clear_in();
        model_apply();
        cmp_state("R9 ignored while busy");

        // R11: push wins over pop on both stacks
        start_op(1, 1, 4'h9, 0, 0, 12'h0, 0, 0, 8'h0);
        chk("R11 es push chosen", 32'(ram_we), 1);
        finish_op();
        cmp_state("R11 es");
        start_op(0, 0, 4'h0, 1, 1, 12'hFED, 0, 0, 8'h0);
        chk("R11 rs push chosen", 32'(ram_we), 1);
        finish_op();
        cmp_state("R11 rs");

        // R10: operand pointer wrap both ways
        start_op(0, 0, 4'h0, 0, 0, 12'h0, 1, 0, 8'hFF);
        finish_op();
        start_op(1, 0, 4'h3, 0, 0, 12'h0, 0, 0, 8'h0);
        finish_op();
        chk("R10 sp FF->00", 32'(sp), 0);
        start_op(0, 1, 4'h0, 0, 0, 12'h0, 0, 0, 8'h0);
        finish_op();
        chk("R10 sp 00->FF", 32'(sp), 32'hFF);
        cmp_state("R10 wrap");

        // random mix: R2 R3 R4 R5 R7 R8 R11
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            logic lsp, lrp, rsp, rsq;
            r = $urandom;
            lsp = (r[3:0] == 4'd0);
            lrp = (r[3:0] == 4'd1);
            rsp = (r[5:4] == 2'd0) && r[6];
            rsq = (r[5:4] == 2'd0) && r[7];
            start_op(r[8], r[9], r[13:10], rsp, rsq, r[25:14], lsp, lrp, r[31:24]);
            finish_op();
            cmp_state("R7 random");
        end
        cmp_mem("R6 memory image");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule